// File: doc/BRIEF.md
# Edge-Pulse Encoder with Refresh

This block sits at the transmit side of a pulse-only isolation link. A slow logic level enters through a two-flop synchroniser. Every change of that level becomes a single-cycle pulse: a rising change becomes a pulse on the set line, and a falling change becomes a pulse on the clear line. A receiver that holds a bistable latch can rebuild the level from those two pulse lines.

A pulse channel cannot by itself carry a steady level: a lost or corrupted pulse, or a receiver that powered up late, would leave the far side wrong for as long as the input stays still. To prevent this, an idle timer counts the cycles since the last pulse. When it reaches the refresh period, the block sends a refresh pulse that restates the current level. The refresh pulse goes on the set line when the level is high and on the clear line when it is low, and it repeats every period while the input stays still. Any input change restarts the timer. An enable input silences the block and clears its timer. Set `REFRESH_CYCLES` to the clock frequency divided by the refresh rate; for example, 100 at 100 MHz gives one refresh per microsecond.

Top module: `edge_refresh_encoder`

## Requirements
- R1: While reset is asserted, and for the cycles that follow its release before any input change or refresh period has elapsed, both `link_set_o` and `link_clr_o` are 0.
- R2: A 0-to-1 change on `data_i` while enabled produces exactly one `link_set_o` pulse, one cycle wide. The pulse is visible after the third rising clock edge following the change.
- R3: A 1-to-0 change on `data_i` while enabled produces exactly one `link_clr_o` pulse, one cycle wide, with the same three-edge latency.
- R4: `link_set_o` and `link_clr_o` are never 1 in the same cycle.
- R5: When the synchronised input has been high with no pulse sent for `REFRESH_CYCLES` cycles, a refresh pulse appears on `link_set_o`.
- R6: When the synchronised input has been low with no pulse sent for `REFRESH_CYCLES` cycles, a refresh pulse appears on `link_clr_o`.
- R7: While the input stays still, refresh pulses repeat every `REFRESH_CYCLES` cycles.
- R8: Every input change restarts the idle timer. An input that changes at intervals shorter than `REFRESH_CYCLES` produces only edge pulses, one per change, and no refresh pulse.
- R9: An input pulse only one clock cycle wide still produces a set pulse followed one cycle later by a clear pulse.
- R10: While `enable_i` is 0, no pulses are produced, even if the input changes. After `enable_i` returns to 1, a level change made while disabled produces no edge pulse. The first pulse is a refresh pulse, visible `REFRESH_CYCLES` rising edges after the first edge that samples `enable_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | 1 allows pulses; 0 silences outputs and clears the idle timer |
| data_i | input | 1 | Asynchronous logic level to be carried across the link |
| link_set_o | output | 1 | One-cycle pulse: rising change or high-level refresh |
| link_clr_o | output | 1 | One-cycle pulse: falling change or low-level refresh |

## Verification
Single rising and falling steps, each followed by a long still period, show that edge pulses and refresh pulses land on the correct line in the exact cycle, and that refresh repeats at the correct period. A toggle train faster than the refresh period, and a one-cycle input pulse, separate correct restarting of the timer and correct handling of minimum width from designs that insert spurious refreshes or merge adjacent edges. Toggling while disabled, followed by re-enabling, distinguishes a design that clears its timer and drops stale edges from one that leaks pulses across the enable boundary.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [1:0] {
    PULSE_NONE = 2'd0,
    PULSE_SET  = 2'd1,
    PULSE_CLR  = 2'd2
  } pulse_kind_e;
endpackage

// File: rtl/erc_sync.sv
module erc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/erc_edge_detect.sv
module erc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q, prev_d;

  assign prev_d = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/erc_idle_timer.sv
module erc_idle_timer #(
  parameter int PERIOD = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en & ~restart & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                  cnt_d = '0;
    else if (restart || tick) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  wrap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  // R8
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/edge_refresh_encoder.sv
module edge_refresh_encoder
  import erc_pkg::*;
#(
  parameter int REFRESH_CYCLES = 100,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic data_i,
  output logic link_set_o,
  output logic link_clr_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic level, rise, fall, edge_seen, tick;

  erc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(data_i), .q(level)
  );

  erc_edge_detect u_edge (
    .clk(clk), .rst_n(rst_sync_n), .level(level), .rise(rise), .fall(fall)
  );

  assign edge_seen = rise | fall;

  erc_idle_timer #(.PERIOD(REFRESH_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .en(enable_i), .restart(edge_seen), .tick(tick)
  );

  pulse_kind_e kind;
  logic set_d, clr_d, set_q, clr_q;

  always_comb begin
    kind = PULSE_NONE;
    if (enable_i) begin
      if (rise)      kind = PULSE_SET;
      else if (fall) kind = PULSE_CLR;
      else if (tick) kind = level ? PULSE_SET : PULSE_CLR;
    end
    set_d = (kind == PULSE_SET);
    clr_d = (kind == PULSE_CLR);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      set_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      set_q <= set_d;
      clr_q <= clr_d;
    end
  end

  assign link_set_o = set_q;
  assign link_clr_o = clr_q;

  // R4
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(link_set_o && link_clr_o));

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable_i |=> (!link_set_o && !link_clr_o));

  // R2
  rise_to_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable_i && rise) |=> link_set_o);

  // R3
  fall_to_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable_i && fall) |=> link_clr_o);

  // R5
  refresh_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && level) |=> link_set_o);

  // R6
  refresh_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !level) |=> link_clr_o);

  // R2
  set_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_set_o |=> !link_set_o);
endmodule

// File: tb/tb_edge_refresh_encoder.sv
module tb_edge_refresh_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int L = 20;

  logic clk = 1'b0;
  logic rst_n, enable_i, data_i;
  logic link_set_o, link_clr_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_refresh_encoder #(.REFRESH_CYCLES(L), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .data_i(data_i),
    .link_set_o(link_set_o), .link_clr_o(link_clr_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_out(string tag, logic es, logic ec);
    checks++;
    if (link_set_o !== es || link_clr_o !== ec) begin
      failures++;
      $display("FAIL %s: set/clr actual=%b%b expected=%b%b", tag, link_set_o, link_clr_o, es, ec);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_count(int n, inout int sets, inout int clrs);
    int both = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (link_set_o) sets++;
      if (link_clr_o) clrs++;
      if (link_set_o && link_clr_o) both++;
    end
    check_int("R4 both lines high", both, 0);
  endtask

  task automatic quiesce(logic lvl);
    enable_i = 1'b0;
    data_i = lvl;
    for (int i = 0; i < 5; i++) step();
  endtask

  task automatic t_reset();
    int s = 0, c = 0;
    rst_n = 1'b0; enable_i = 1'b1; data_i = 1'b0;
    for (int i = 0; i < 4; i++) step();
    check_out("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    run_count(L - 4, s, c);
    check_int("R1 no set after release", s, 0);
    check_int("R1 no clr after release", c, 0);
  endtask

  task automatic t_rise_refresh();
    int s = 0, c = 0;
    quiesce(1'b0);
    enable_i = 1'b1; data_i = 1'b1;
    step(); step();
    check_out("R2 before latency", 1'b0, 1'b0);
    step();
    check_out("R2 rise pulse", 1'b1, 1'b0);
    step();
    check_out("R2 pulse one cycle", 1'b0, 1'b0);
    run_count(L - 2, s, c);
    check_int("R5 quiet before refresh", s + c, 0);
    step();
    check_out("R5 high refresh", 1'b1, 1'b0);
    run_count(L - 1, s, c);
    check_int("R7 quiet between refreshes", s + c, 0);
    step();
    check_out("R7 second refresh", 1'b1, 1'b0);
  endtask

  task automatic t_fall_refresh();
    int s = 0, c = 0;
    quiesce(1'b1);
    enable_i = 1'b1; data_i = 1'b0;
    step(); step(); step();
    check_out("R3 fall pulse", 1'b0, 1'b1);
    step();
    check_out("R3 pulse one cycle", 1'b0, 1'b0);
    run_count(L - 2, s, c);
    check_int("R6 quiet before refresh", s + c, 0);
    step();
    check_out("R6 low refresh", 1'b0, 1'b1);
  endtask

  task automatic t_toggle_train();
    int s = 0, c = 0;
    quiesce(1'b0);
    enable_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      data_i = ~data_i;
      run_count(L / 2, s, c);
    end
    check_int("R8 set pulses in train", s, 3);
    check_int("R8 clr pulses in train", c, 3);
  endtask

  task automatic t_narrow();
    quiesce(1'b0);
    enable_i = 1'b1; data_i = 1'b1;
    step();
    data_i = 1'b0;
    step(); step();
    check_out("R9 narrow set", 1'b1, 1'b0);
    step();
    check_out("R9 narrow clr", 1'b0, 1'b1);
    step();
    check_out("R9 narrow after", 1'b0, 1'b0);
  endtask

  task automatic t_disable();
    int s = 0, c = 0;
    quiesce(1'b0);
    for (int i = 0; i < 8; i++) begin
      data_i = ~data_i;
      run_count(2, s, c);
    end
    data_i = 1'b1;
    run_count(2 * L, s, c);
    check_int("R10 pulses while disabled", s + c, 0);
    enable_i = 1'b1;
    run_count(L - 1, s, c);
    check_int("R10 no stale edge after enable", s + c, 0);
    step();
    check_out("R10 first refresh after enable", 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_rise_refresh();
    t_fall_refresh();
    t_toggle_train();
    t_narrow();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule